// File: doc/BRIEF.md
# System-control Status/Cause register block with software-interrupt request

This block holds the system-control registers of a small 32-bit core: a Status word, a Cause word, the exception program counter, and a general array for every other register index. The low six bits of Status form a three-level mode/enable stack. Taking an exception pushes the stack by two bits. A return-from-exception strobe pops it by two bits. The core reads and writes the registers through a single write port and a registered read port.

On exception entry the block records the exception code and whether the faulting instruction sat in a branch-delay slot. It also captures the return address. A software-interrupt request is raised whenever an enabled software-pending bit in Cause matches its mask bit in Status while global enable is on. This request is re-evaluated every time Status or Cause changes, so a single Status write can unmask an interrupt that is already pending.

Top module: `sysctl_cp0`

## Requirements
- R1: After synchronous reset, Status, Cause, EPC, `irq` and `rd_data` are all zero.
- R2: A `rfe_i` pulse replaces Status bits 3:0 with the old bits 5:2. Bits 5:4 and bits 31:6 keep their values.
- R3: A write to index 13 stores the data into Cause with bits 15:10 forced to zero.
- R4: `irq` is a register. In the cycle after any update it equals `Status[0] AND ((Cause[9:8] AND Status[9:8]) != 0)`, computed on the updated values.
- R5: An `exc_take_i` pulse shifts Status bits 3:0 into bits 5:2 and clears bits 1:0. Bits 31:6 are kept.
- R6: An `exc_take_i` pulse loads Cause bits 6:2 with `exc_code_i` and Cause bit 31 with `exc_bd_i`, leaving the other Cause bits unchanged. It loads EPC with `pc_i`, or with `pc_i - 4` when `exc_bd_i` is 1. EPC is always visible on `epc`.
- R7: A write to any index other than 12, 13 and 14 stores the value unchanged in a general array that is not reset. Indices 12, 13 and 14 read Status, Cause and EPC. `rd_data` shows, one cycle after `rd_idx`, the value held before that cycle's update.
- R8: Priority per cycle is exception first, then RFE, then the write port. A lower-priority action in the same cycle is dropped, including a general-array write.
- R9: A write to index 12 stores the full 32-bit value into Status, and a write to index 14 stores the full value into EPC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 5 | Register index written |
| wr_data | input | 32 | Write data |
| rd_idx | input | 5 | Register index read |
| rd_data | output | 32 | Read data, one cycle after `rd_idx` |
| rfe_i | input | 1 | Return-from-exception stack pop |
| exc_take_i | input | 1 | Exception entry strobe |
| exc_code_i | input | 5 | Exception code recorded in Cause |
| exc_bd_i | input | 1 | Faulting instruction was in a branch-delay slot |
| pc_i | input | 32 | Current program counter |
| irq | output | 1 | Registered software-interrupt request |
| epc | output | 32 | Exception program counter |

## Verification
The assertions rely on synchronous reset being applied before the first checked edge. They also rely on the strobes being used with the stated priority, so that when several of them are asserted together only the highest-priority one's effect is checked. The random stimulus applies every combination of strobes, including an exception, an RFE and a write all in one cycle, so that the priority cases are exercised rather than avoided. Before any random read, the bench first writes every general-array index, so that each read targets a defined value. It also steers write indices towards 12, 13 and 14, and biases Status and Cause data towards the software bits and the global enable so that `irq` toggles often.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DATA_W     = 32;
  localparam int IDX_W      = 5;
  localparam int STATUS_IDX = 12;
  localparam int CAUSE_IDX  = 13;
  localparam int EPC_IDX    = 14;

  typedef enum logic [1:0] {
    RSEL_GEN    = 2'd0,
    RSEL_STATUS = 2'd1,
    RSEL_CAUSE  = 2'd2,
    RSEL_EPC    = 2'd3
  } rsel_e;

  function automatic logic swi_pending(input logic [1:0] pend,
                                       input logic [1:0] mask,
                                       input logic       gie);
    return gie && (|(pend & mask));
  endfunction
endpackage

// File: rtl/sysctl_status_stack.sv
module sysctl_status_stack #(
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 5,
  parameter int STACK_W    = 6,
  parameter int STATUS_IDX = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rfe,
  input  logic              exc_take,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] status_d
);
  localparam int LVL_W = 2;

  always_comb begin
    status_d = status_q;
    if (exc_take) begin
      status_d[STACK_W-1:0] = {status_q[STACK_W-LVL_W-1:0], {LVL_W{1'b0}}};
    end else if (rfe) begin
      status_d[STACK_W-LVL_W-1:0] = status_q[STACK_W-1:LVL_W];
    end else if (wr_en && (wr_idx == IDX_W'(STATUS_IDX))) begin
      status_d = wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_d;
  end

  AST_RFE_POP: assert property (@(posedge clk) disable iff (rst)
    (rfe && !exc_take) |=> (status_q[STACK_W-LVL_W-1:0] == $past(status_q[STACK_W-1:LVL_W]))
                         && (status_q[DATA_W-1:STACK_W-LVL_W] == $past(status_q[DATA_W-1:STACK_W-LVL_W]))); // R2

  AST_EXC_PUSH: assert property (@(posedge clk) disable iff (rst)
    exc_take |=> (status_q[STACK_W-1:LVL_W] == $past(status_q[STACK_W-LVL_W-1:0]))
              && (status_q[LVL_W-1:0] == '0)); // R5

  AST_STATUS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rfe && !exc_take && wr_idx == IDX_W'(STATUS_IDX)) |=> (status_q == $past(wr_data))); // R9
endmodule

// File: rtl/sysctl_cause_epc.sv
module sysctl_cause_epc #(
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 5,
  parameter int CAUSE_IDX = 13,
  parameter int EPC_IDX   = 14,
  parameter int CODE_LSB  = 2,
  parameter int CODE_W    = 5,
  parameter int BD_BIT    = 31,
  parameter int CLR_LSB   = 10,
  parameter int CLR_W     = 6,
  parameter int PC_STEP   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              exc_take,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              exc_bd,
  input  logic [DATA_W-1:0] pc,
  output logic [DATA_W-1:0] cause_q,
  output logic [DATA_W-1:0] cause_d,
  output logic [DATA_W-1:0] epc_q
);
  localparam logic [DATA_W-1:0] CLR_MASK = ~(((DATA_W'(1) << CLR_W) - 1) << CLR_LSB);
  localparam logic [DATA_W-1:0] STEP     = DATA_W'(PC_STEP);

  logic [DATA_W-1:0] epc_d;

  always_comb begin
    cause_d = cause_q;
    epc_d   = epc_q;
    if (exc_take) begin
      cause_d[CODE_LSB +: CODE_W] = exc_code;
      cause_d[BD_BIT]             = exc_bd;
      epc_d                       = exc_bd ? (pc - STEP) : pc;
    end else if (wr_en && (wr_idx == IDX_W'(CAUSE_IDX))) begin
      cause_d = wr_data & CLR_MASK;
    end else if (wr_en && (wr_idx == IDX_W'(EPC_IDX))) begin
      epc_d = wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      epc_q   <= '0;
    end else begin
      cause_q <= cause_d;
      epc_q   <= epc_d;
    end
  end

  AST_CAUSE_MASK: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !exc_take && wr_idx == IDX_W'(CAUSE_IDX)) |=> (cause_q[CLR_LSB +: CLR_W] == '0)); // R3

  AST_EXC_CODE: assert property (@(posedge clk) disable iff (rst)
    exc_take |=> (cause_q[CODE_LSB +: CODE_W] == $past(exc_code)) && (cause_q[BD_BIT] == $past(exc_bd))); // R6

  AST_EPC_DELAY: assert property (@(posedge clk) disable iff (rst)
    (exc_take && exc_bd) |=> (epc_q == $past(pc) - STEP)); // R6
endmodule

// File: rtl/sysctl_swi_detect.sv
module sysctl_swi_detect #(
  parameter int SW_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SW_W-1:0] pend_d,
  input  logic [SW_W-1:0] mask_d,
  input  logic            gie_d,
  output logic            irq_q
);
  logic hit;

  always_comb hit = gie_d && (|(pend_d & mask_d));

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= hit;
  end
endmodule

// File: rtl/sysctl_gen_regs.sv
module sysctl_gen_regs #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sysctl_cp0.sv
module sysctl_cp0
  import sysctl_pkg::*;
#(
  parameter int DW      = sysctl_pkg::DATA_W,
  parameter int IW      = sysctl_pkg::IDX_W,
  parameter int STACK_W = 6,
  parameter int CODE_W  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic          rfe_i,
  input  logic          exc_take_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic          exc_bd_i,
  input  logic [DW-1:0] pc_i,
  output logic          irq,
  output logic [DW-1:0] epc
);
  localparam int SW_LSB = 8;
  localparam int SW_W   = 2;

  logic          wr_ok;
  logic [DW-1:0] status_q, status_d, cause_q, cause_d, epc_q;
  logic [DW-1:0] gen_q, spec_q;
  logic          is_special_wr;
  rsel_e         rsel_q;

  always_comb begin
    wr_ok         = wr_en && !rfe_i && !exc_take_i;
    is_special_wr = (wr_idx == IW'(STATUS_IDX)) || (wr_idx == IW'(CAUSE_IDX))
                 || (wr_idx == IW'(EPC_IDX));
  end

  sysctl_status_stack #(
    .DATA_W(DW), .IDX_W(IW), .STACK_W(STACK_W), .STATUS_IDX(STATUS_IDX)
  ) u_status (
    .clk(clk), .rst(rst), .wr_en(wr_ok), .wr_idx(wr_idx), .wr_data(wr_data),
    .rfe(rfe_i), .exc_take(exc_take_i), .status_q(status_q), .status_d(status_d)
  );

  sysctl_cause_epc #(
    .DATA_W(DW), .IDX_W(IW), .CAUSE_IDX(CAUSE_IDX), .EPC_IDX(EPC_IDX), .CODE_W(CODE_W)
  ) u_cause (
    .clk(clk), .rst(rst), .wr_en(wr_ok), .wr_idx(wr_idx), .wr_data(wr_data),
    .exc_take(exc_take_i), .exc_code(exc_code_i), .exc_bd(exc_bd_i), .pc(pc_i),
    .cause_q(cause_q), .cause_d(cause_d), .epc_q(epc_q)
  );

  sysctl_swi_detect #(.SW_W(SW_W)) u_swi (
    .clk(clk), .rst(rst),
    .pend_d(cause_d[SW_LSB +: SW_W]), .mask_d(status_d[SW_LSB +: SW_W]),
    .gie_d(status_d[0]), .irq_q(irq)
  );

  sysctl_gen_regs #(.DATA_W(DW), .IDX_W(IW)) u_gen (
    .clk(clk), .we(wr_ok && !is_special_wr), .waddr(wr_idx), .wdata(wr_data),
    .raddr(rd_idx), .rdata(gen_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q <= RSEL_STATUS;
      spec_q <= '0;
    end else begin
      if (rd_idx == IW'(STATUS_IDX)) begin
        rsel_q <= RSEL_STATUS; spec_q <= status_q;
      end else if (rd_idx == IW'(CAUSE_IDX)) begin
        rsel_q <= RSEL_CAUSE;  spec_q <= cause_q;
      end else if (rd_idx == IW'(EPC_IDX)) begin
        rsel_q <= RSEL_EPC;    spec_q <= epc_q;
      end else begin
        rsel_q <= RSEL_GEN;    spec_q <= '0;
      end
    end
  end

  always_comb begin
    rd_data = (rsel_q == RSEL_GEN) ? gen_q : spec_q;
    epc     = epc_q;
  end

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
    irq |-> status_q[0]); // R4

  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (rst)
    (status_q[0] && (|(cause_q[SW_LSB +: SW_W] & status_q[SW_LSB +: SW_W]))) |-> irq); // R4

  AST_EXC_OVER_RFE: assert property (@(posedge clk) disable iff (rst)
    (exc_take_i && rfe_i) |=> (status_q[1:0] == 2'b00)); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (!irq && status_q == '0 && cause_q == '0 && epc_q == '0)); // R1
endmodule

// File: tb/sysctl_cp0_bench.sv
module sysctl_cp0_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;
  logic [4:0]  rd_idx;
  logic [31:0] rd_data;
  logic        rfe_i, exc_take_i, exc_bd_i;
  logic [4:0]  exc_code_i;
  logic [31:0] pc_i;
  logic        irq;
  logic [31:0] epc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_status, m_cause, m_epc;
  logic [31:0] m_gen [32];

  always #4 clk = ~clk;

  sysctl_cp0 u_sysctl_cp0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .rfe_i(rfe_i), .exc_take_i(exc_take_i),
    .exc_code_i(exc_code_i), .exc_bd_i(exc_bd_i), .pc_i(pc_i), .irq(irq), .epc(epc)
  );

  function automatic logic [31:0] model_read(input logic [4:0] idx);
    if (idx == 5'd12) return m_status;
    if (idx == 5'd13) return m_cause;
    if (idx == 5'd14) return m_epc;
    return m_gen[idx];
  endfunction

  function automatic logic model_irq();
    return m_status[0] && (|(m_cause[9:8] & m_status[9:8]));
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [4:0] wi, input logic [31:0] wd,
                      input logic [4:0] ri, input logic rf, input logic ex,
                      input logic [4:0] code, input logic bd, input logic [31:0] pc,
                      input string req);
    logic [31:0] exp_rd;
    wr_en = we; wr_idx = wi; wr_data = wd; rd_idx = ri;
    rfe_i = rf; exc_take_i = ex; exc_code_i = code; exc_bd_i = bd; pc_i = pc;
    exp_rd = model_read(ri);
    if (ex) begin
      m_status[5:0] = {m_status[3:0], 2'b00};
      m_cause[6:2]  = code;
      m_cause[31]   = bd;
      m_epc         = bd ? pc - 32'd4 : pc;
    end else if (rf) begin
      m_status[3:0] = m_status[5:2];
    end else if (we) begin
      if (wi == 5'd12)      m_status = wd;
      else if (wi == 5'd13) m_cause  = wd & 32'hFFFF03FF;
      else if (wi == 5'd14) m_epc    = wd;
      else                  m_gen[wi] = wd;
    end
    @(negedge clk);
    chk(rd_data === exp_rd, {req, " rd_data (R7)"}, rd_data, exp_rd);
    chk(irq === model_irq(), {req, " irq (R4)"}, {31'd0, irq}, {31'd0, model_irq()});
    chk(epc === m_epc, {req, " epc (R6)"}, epc, m_epc);
  endtask

  task automatic idle_read(input logic [4:0] ri, input string req);
    step(1'b0, 5'd0, 32'd0, ri, 1'b0, 1'b0, 5'd0, 1'b0, 32'd0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd2024);
    wr_en = 0; wr_idx = 0; wr_data = 0; rd_idx = 12; rfe_i = 0; exc_take_i = 0;
    exc_code_i = 0; exc_bd_i = 0; pc_i = 0;
    m_status = 0; m_cause = 0; m_epc = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk(rd_data === 32'd0, "R1 rd_data", rd_data, 0);
    chk(irq === 1'b0, "R1 irq", {31'd0, irq}, 0);
    chk(epc === 32'd0, "R1 epc", epc, 0);
    idle_read(5'd12, "R1 status");
    idle_read(5'd13, "R1 cause");
    // fill general array (R7)
    for (int i = 0; i < 32; i++) begin
      step(1'b1, 5'(i), $urandom, 5'd12, 1'b0, 1'b0, 5'd0, 1'b0, 32'd0, "R7 fill");
    end
    m_status = 0; m_cause = 0; m_epc = 0;
    rst = 1; @(negedge clk); rst = 0;
    for (int i = 0; i < 32; i++) idle_read(5'(i), "R7 readback");
    // R9 + R2: status 0x3C then pop -> 0x3F
    step(1'b1, 5'd12, 32'h0000_003C, 5'd12, 1'b0, 1'b0, 5'd0, 1'b0, 32'd0, "R9 status write");
    step(1'b0, 5'd0, 32'd0, 5'd12, 1'b1, 1'b0, 5'd0, 1'b0, 32'd0, "R2 rfe");
    idle_read(5'd12, "R2 pop result");
    chk(m_status == 32'h3F, "R2 model", m_status, 32'h3F);
    // R3: cause write clears 15:10
    step(1'b1, 5'd13, 32'hFFFF_FFFF, 5'd13, 1'b0, 1'b0, 5'd0, 1'b0, 32'd0, "R3 cause write");
    idle_read(5'd13, "R3 cause mask");
    // R4: unmask software interrupt via status write
    step(1'b1, 5'd12, 32'h0000_0101, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 32'd0, "R4 unmask");
    chk(irq === 1'b1, "R4 irq raised", {31'd0, irq}, 1);
    step(1'b1, 5'd12, 32'h0000_0100, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 32'd0, "R4 gie off");
    chk(irq === 1'b0, "R4 irq dropped", {31'd0, irq}, 0);
    // R5/R6: exception (syscall code 8) in delay slot
    step(1'b1, 5'd12, 32'h0000_000F, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 32'd0, "R9 status");
    step(1'b0, 5'd0, 32'd0, 5'd12, 1'b0, 1'b1, 5'd8, 1'b1, 32'h0000_0100, "R6 exc bd");
    chk(epc === 32'h0000_00FC, "R6 epc pc-4", epc, 32'hFC);
    idle_read(5'd12, "R5 status push");
    chk(m_status[5:0] == 6'h3C, "R5 model", {26'd0, m_status[5:0]}, 32'h3C);
    idle_read(5'd13, "R6 cause code");
    step(1'b0, 5'd0, 32'd0, 5'd13, 1'b0, 1'b1, 5'd4, 1'b0, 32'h0000_2000, "R6 exc no bd");
    idle_read(5'd13, "R6 cause bd clear");
    // R8: all three strobes together, general write dropped
    step(1'b1, 5'd3, 32'hDEAD_BEEF, 5'd3, 1'b1, 1'b1, 5'd9, 1'b0, 32'h40, "R8 all strobes");
    idle_read(5'd3, "R8 gen write dropped");
    step(1'b1, 5'd12, 32'h1234_5678, 5'd12, 1'b1, 1'b0, 5'd0, 1'b0, 32'd0, "R8 rfe over write");
    idle_read(5'd12, "R8 status kept");
    // R9: EPC write
    step(1'b1, 5'd14, 32'hCAFE_0001, 5'd14, 1'b0, 1'b0, 5'd0, 1'b0, 32'd0, "R9 epc write");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [4:0]  wi;
      logic [31:0] wd;
      logic [2:0]  pick;
      pick = 3'($urandom_range(0, 7));
      wi = (pick < 3) ? 5'(12 + pick) : 5'($urandom_range(0, 31));
      wd = $urandom;
      if ($urandom_range(0, 1) == 1) wd = wd & 32'h0000_03FF;
      step($urandom_range(0, 9) < 4, wi, wd, 5'($urandom_range(0, 31)),
           $urandom_range(0, 9) == 0, $urandom_range(0, 11) == 0,
           5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)), $urandom,
           "R2 R3 R5 R8 random");
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule